// File: doc/BRIEF.md
# Zero-Crossing Triggered Complementary Gate Driver

This block drives the two switches of one leg of a boundary-conduction power-factor stage: a main (active) switch and a synchronous rectifier switch. There is no fixed period. Each switching cycle opens when an up-counter is cleared, which turns the main switch on. When the counter reaches the on-time compare value, the main switch turns off and, after a rising-edge dead time, the synchronous switch turns on. A rising edge on the zero-current-detect input ends the synchronous conduction. The synchronous switch stays on for a further falling-edge delay, which sets how long negative inductor current is allowed to flow, and then turns off. After a restart delay equal to the second dead time, the counter clears and the next cycle begins.

Each dead time is owned by a single value. The rising-edge delay separates main-off from synchronous-on. The restart delay separates synchronous-off from main-on. Because of this, no setting of the values can make the two gates conduct together. The on-time compare value and the falling-edge delay are the values a control loop updates while running. Both are taken from their input ports only at the counter-clear event, so every cycle uses one consistent pair. If no zero-current edge ever arrives, a count ceiling ends the synchronous conduction as if the edge had come. This keeps the stage from locking up at start-up.

Top module: `zcd_gate_pair`

## Requirements
- R1: While `rst_n` is low both gate outputs are 0. At the first rising clock edge after reset is released, a new cycle starts and `gate_act_o` goes to 1.
- R2: `gate_act_o` stays high for exactly `cmpa_i` clock cycles, using the value captured at the cycle start. A captured value of 0 acts as 1.
- R3: `gate_sync_o` rises max(`red_i`,1) clock cycles after `gate_act_o` falls.
- R4: A 0-to-1 transition of `zcd_i` while the synchronous switch is commanded on is seen through a two-flop synchronizer and an edge detector. `gate_sync_o` then falls 3 + max(F,1) clock edges after the transition, where F is the falling-edge delay captured at the cycle start.
- R5: After `gate_sync_o` falls, the counter clears and `gate_act_o` rises max(`sd_i`,1) clock cycles later.
- R6: `gate_act_o` and `gate_sync_o` are never 1 in the same cycle.
- R7: `cmpa_i` and `fed_i` are sampled only when the counter clears. Changing them during a cycle has no effect until the next cycle.
- R8: A rising `zcd_i` edge that arrives while the synchronous switch is not yet commanded on (during the main on-time) is ignored. It changes neither the on-time nor the rising-edge dead time.
- R9: If no zero-current edge arrives, the synchronous switch is commanded off when the counter reaches `MAX_CNT`. `gate_sync_o` then falls MAX_CNT + 1 + max(F,1) cycles after `gate_act_o` rose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| zcd_i | input | 1 | Zero-current-detect input, asynchronous |
| cmpa_i | input | CW | Main-switch on-time in cycles (shadowed) |
| red_i | input | DW | Dead time from main-off to synchronous-on |
| fed_i | input | DW | Synchronous hold after the zero-current edge (shadowed) |
| sd_i | input | DW | Dead time from synchronous-off to main-on |
| gate_act_o | output | 1 | Main switch gate |
| gate_sync_o | output | 1 | Synchronous switch gate |

## Verification
A table of settings drives back-to-back cycles. Each row measures the main on-time, both dead times and the zero-current-to-turn-off latency. The rows include all-zero values that must clamp to one cycle, minimum ones, long on-times and wide delays, so an off-by-one in any single counter shows up on its own. Directed cycles change the compare and hold values in mid-cycle to separate shadowed loading from direct use. They also pulse the zero-current input during the main on-time to prove it is ignored, and they withhold it entirely to exercise the count ceiling. A monitor watches every cycle for the two gates being high together.

// File: rtl/zcd_gate_pair.sv
module zcd_gate_pair #(
  parameter int CW      = 10,
  parameter int DW      = 8,
  parameter int MAX_CNT = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          zcd_i,
  input  logic [CW-1:0] cmpa_i,
  input  logic [DW-1:0] red_i,
  input  logic [DW-1:0] fed_i,
  input  logic [DW-1:0] sd_i,
  output logic          gate_act_o,
  output logic          gate_sync_o
);
  localparam logic [CW-1:0] CNT_TOP = CW'(MAX_CNT);

  logic          z1, z2, z3;
  logic [CW-1:0] cnt, cmp_q;
  logic [DW-1:0] fed_q, dcnt, sdc;
  logic          aq_sync, sd_run;

  wire [CW-1:0] cnt_inc  = cnt + 1'b1;
  wire [DW-1:0] dcnt_inc = dcnt + 1'b1;
  wire [DW-1:0] sdc_inc  = sdc + 1'b1;

  wire t1       = z2 & ~z3;
  wire to_hit   = (cnt == CNT_TOP);
  wire idle     = !aq_sync && !gate_sync_o && !sd_run;
  wire zero_ev  = (sd_run && (sdc_inc >= sd_i)) || (to_hit && idle);
  wire clr_ev   = aq_sync && (t1 || to_hit);
  wire cmp_ev   = !zero_ev && !to_hit && (cnt_inc == cmp_q);
  wire red_done = aq_sync && !gate_sync_o && (dcnt_inc >= red_i);
  wire fed_done = !aq_sync && gate_sync_o && (dcnt_inc >= fed_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {z3, z2, z1} <= '0;
      cnt          <= CNT_TOP;
      cmp_q        <= CW'(1);
      fed_q        <= DW'(1);
      gate_act_o   <= 1'b0;
      aq_sync      <= 1'b0;
      gate_sync_o  <= 1'b0;
      dcnt         <= '0;
      sd_run       <= 1'b0;
      sdc          <= '0;
    end else begin
      {z3, z2, z1} <= {z2, z1, zcd_i};
      cnt <= zero_ev ? '0 : (to_hit ? cnt : cnt_inc);

      if (zero_ev) begin
        cmp_q      <= (cmpa_i == '0) ? CW'(1) : cmpa_i;
        fed_q      <= fed_i;
        gate_act_o <= 1'b1;
      end else if (cmp_ev) begin
        gate_act_o <= 1'b0;
      end

      if (cmp_ev)      aq_sync <= 1'b1;
      else if (clr_ev) aq_sync <= 1'b0;

      if (red_done) begin
        gate_sync_o <= 1'b1;
        dcnt        <= '0;
      end else if (fed_done) begin
        gate_sync_o <= 1'b0;
        dcnt        <= '0;
      end else if (aq_sync != gate_sync_o) begin
        dcnt <= dcnt_inc;
      end else begin
        dcnt <= '0;
      end

      if (fed_done) begin
        sd_run <= 1'b1;
        sdc    <= '0;
      end else if (zero_ev) begin
        sd_run <= 1'b0;
      end else if (sd_run) begin
        sdc <= sdc_inc;
      end
    end
  end

  p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_act_o && gate_sync_o));

  p_act_after_sync_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_act_o) |-> !gate_sync_o && $past(!gate_sync_o));

  p_sync_after_act_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_sync_o) |-> !gate_act_o && $past(!gate_act_o));

  p_fed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aq_sync) && $past(gate_sync_o) |-> gate_sync_o);

  p_shadow_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmp_q) || !$stable(fed_q) |-> $rose(gate_act_o) || $past(gate_act_o));

endmodule

// File: tb/zcd_gate_pair_tb_top.sv
`timescale 1ns/1ps
module zcd_gate_pair_tb_top;
  localparam int CW = 10, DW = 8, TOP = 1000;

  logic clk = 1'b0, rst_n = 1'b0, zcd = 1'b0;
  logic [CW-1:0] cmpa;
  logic [DW-1:0] red, fed, sd;
  logic act, syn;
  int checks = 0, fails = 0, overlaps = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  zcd_gate_pair #(.CW(CW), .DW(DW), .MAX_CNT(TOP)) dut_i (
    .clk(clk), .rst_n(rst_n), .zcd_i(zcd), .cmpa_i(cmpa), .red_i(red),
    .fed_i(fed), .sd_i(sd), .gate_act_o(act), .gate_sync_o(syn));

  // cmpa, red, fed, sd, hold-before-zcd
  localparam int VEC [6][5] = '{
    '{12,  3,  4,  2,  5},
    '{ 0,  0,  0,  0,  0},
    '{ 1,  1,  1,  1,  2},
    '{40, 10, 20,  8,  3},
    '{ 7, 25,  5,  3,  1},
    '{25,  2,  1, 15, 10}
  };

  function automatic int m1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && act && syn) overlaps++;

  task automatic run_cycle(int c, int r, int f, int s, int h, bit chk_gap,
                           bit early, int c_new, int f_new);
    int g, a, d, k;
    cmpa = CW'(c); red = DW'(r); fed = DW'(f); sd = DW'(s);
    g = 0;
    while (!act) begin @(negedge clk); g++; end
    if (chk_gap) chk("R5 restart dead time", g, m1(s));
    a = 0;
    while (act) begin
      if (a == 1) begin cmpa = CW'(c_new); fed = DW'(f_new); end
      if (early && a == 2) zcd = 1'b1;
      if (early && a == 5) zcd = 1'b0;
      a++;
      @(negedge clk);
    end
    chk(early ? "R8 early zcd on-time" : "R2 on-time", a, m1(c));
    d = 0;
    while (!syn) begin d++; @(negedge clk); end
    chk(early ? "R8 early zcd red" : "R3 rising dead time", d, m1(r));
    repeat (h) @(negedge clk);
    zcd = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (syn);
    chk("R4 zcd to sync off", k, 3 + m1(f));
    zcd = 1'b0;
  endtask

  initial begin
    int k;
    bit seen;
    cmpa = CW'(VEC[0][0]); red = DW'(VEC[0][1]); fed = DW'(VEC[0][2]); sd = DW'(VEC[0][3]);
    repeat (3) @(negedge clk);
    chk("R1 act in reset", int'(act), 0);
    chk("R1 sync in reset", int'(syn), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 act after release", int'(act), 1);

    for (int i = 0; i < 6; i++)
      run_cycle(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4],
                i != 0, 1'b0, VEC[i][0], VEC[i][2]);

    // R7: mid-cycle writes apply to the following cycle only
    run_cycle(15, 2, 3, 2, 4, 1'b1, 1'b0, 5, 9);
    run_cycle(5, 2, 9, 2, 4, 1'b1, 1'b0, 5, 9);
    chk("R7 shadow cycles done", int'(act), 0);

    // R8: zcd pulse during main on-time is ignored
    run_cycle(20, 3, 2, 2, 3, 1'b1, 1'b1, 20, 2);

    // R9: no zcd, count ceiling ends sync conduction
    cmpa = CW'(10); red = DW'(2); fed = DW'(4); sd = DW'(3);
    while (!act) @(negedge clk);
    k = 0; seen = 1'b0;
    while (!(seen && !syn)) begin
      @(negedge clk); k++;
      if (syn) seen = 1'b1;
    end
    chk("R9 timeout sync off", k, TOP + 1 + 4);

    chk("R6 overlap cycles", overlaps, 0);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 act after re-reset", int'(act), 0);
    chk("R1 sync after re-reset", int'(syn), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule